// File: doc/BRIEF.md
# Windowed 2D Matrix Storage Cache

This block stores a matrix of 32-bit words in an array of independent memory banks and presents it to its clients as a 2D space addressed by (row, column). The matrix is cut into tiles of `WIN_H` rows by `WIN_W` columns. The `WIN_H*WIN_W` elements of one tile all live at the same address, each in a different bank. Because of this, a whole tile, or any single row or column of a tile, can be moved in a single clock cycle.

There is one write port and one read port. Each has its own coordinates, data bus and access-shape selector. The four access shapes are a single element, a row slice, a column slice and a full tile. The block converts each coordinate pair into one in-bank address and a set of bank selects. It then packs lanes into banks on a write and unpacks banks into lanes on a read. Both matrix dimensions and both tile dimensions are parameters and must be powers of two. Under this restriction the in-bank address `floor(row/WIN_H)*(MAT_W/WIN_W) + floor(col/WIN_W)` reduces to a concatenation of coordinate bits.

Top module: `mat_window_store`

## Requirements
- R1: Element (y, x) is held in bank (y mod WIN_H)*WIN_W + (x mod WIN_W), at the in-bank address that is shared by its whole tile. Seen through a full-tile read of its tile, it appears on lane (y mod WIN_H)*WIN_W + (x mod WIN_W).
- R2: Mode 0 (single element) writes lane 0 of the write data to (row, col) and touches nothing else. A mode 0 read returns (row, col) on lane 0.
- R3: Mode 1 (row slice) reaches the WIN_W elements (row, col+c) for c = 0..WIN_W-1 on lanes c. The column must be a multiple of WIN_W; the row may be any row.
- R4: Mode 2 (column slice) reaches the WIN_H elements (row+r, col) for r = 0..WIN_H-1 on lanes r. The row must be a multiple of WIN_H; the column may be any column.
- R5: Mode 3 (full tile) reaches element (row+r, col+c) on lane r*WIN_W+c. Both coordinates must be tile-aligned.
- R6: Read data and `rd_valid` appear in the cycle after an accepted read request. `rd_valid` is never high without a request in the previous cycle.
- R7: On a read, every lane that the mode does not use is zero. These are lanes 1 and up in mode 0, lanes WIN_W and up in mode 1, and lanes WIN_H and up in mode 2.
- R8: A slice write changes only the banks of its row or column. All other elements of the tile keep their contents.
- R9: A row-slice, column-slice or tile request whose coordinate is not aligned in an accessed dimension is ignored. A misaligned write leaves the storage unchanged and raises `wr_err` in the next cycle. A misaligned read raises `rd_err` in the next cycle, keeps `rd_valid` low, and leaves `rd_data` unchanged.
- R10: When a read and a write reach the same bank address in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_mode | input | 2 | Write shape: 0 element, 1 row slice, 2 column slice, 3 tile |
| wr_row | input | log2(MAT_H) | Write row coordinate |
| wr_col | input | log2(MAT_W) | Write column coordinate |
| wr_data | input | WIN_H*WIN_W*DW | Write lanes, lane k at bits k*DW upward |
| wr_err | output | 1 | Previous write request was misaligned and dropped |
| rd_en | input | 1 | Read request |
| rd_mode | input | 2 | Read shape, same coding as wr_mode |
| rd_row | input | log2(MAT_H) | Read row coordinate |
| rd_col | input | log2(MAT_W) | Read column coordinate |
| rd_data | output | WIN_H*WIN_W*DW | Read lanes, unused lanes zero |
| rd_valid | output | 1 | rd_data carries the result of the previous cycle's read |
| rd_err | output | 1 | Previous read request was misaligned and dropped |

## Verification
A read and a write can land on the same tile address in the same clock edge. The bench provokes this by raising both requests in one cycle on the same tile: a full-tile write over a known old pattern together with a full-tile read. The returned lanes must equal the old pattern. A second read must then return the newly written data, which shows the write was not lost in the collision.

// File: rtl/mat_window_store.sv
module mat_window_store #(
  parameter int DW    = 32,
  parameter int WIN_H = 4,
  parameter int WIN_W = 4,
  parameter int MAT_H = 32,
  parameter int MAT_W = 64,
  localparam int NB    = WIN_H * WIN_W,
  localparam int LH    = $clog2(WIN_H),
  localparam int LW    = $clog2(WIN_W),
  localparam int RW    = $clog2(MAT_H),
  localparam int CW    = $clog2(MAT_W),
  localparam int AW    = (RW - LH) + (CW - LW),
  localparam int DEPTH = 1 << AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_mode,
  input  logic [RW-1:0]      wr_row,
  input  logic [CW-1:0]      wr_col,
  input  logic [NB*DW-1:0]   wr_data,
  output logic               wr_err,
  input  logic               rd_en,
  input  logic [1:0]         rd_mode,
  input  logic [RW-1:0]      rd_row,
  input  logic [CW-1:0]      rd_col,
  output logic [NB*DW-1:0]   rd_data,
  output logic               rd_valid,
  output logic               rd_err
);

  function automatic logic on_grid(input logic [1:0] m, input logic [RW-1:0] y,
                                   input logic [CW-1:0] x);
    return !((m[0] && x[LW-1:0] != '0) || (m[1] && y[LH-1:0] != '0));
  endfunction

  wire          wr_ok = wr_en && on_grid(wr_mode, wr_row, wr_col);
  wire          rd_ok = rd_en && on_grid(rd_mode, rd_row, rd_col);
  wire [AW-1:0] wa    = {wr_row[RW-1:LH], wr_col[CW-1:LW]};
  wire [AW-1:0] ra    = {rd_row[RW-1:LH], rd_col[CW-1:LW]};
  wire [LH-1:0] wy    = wr_row[LH-1:0];
  wire [LW-1:0] wx    = wr_col[LW-1:0];

  logic [DW-1:0] bank_q [NB];
  logic [1:0]    rs_mode;
  logic [LH-1:0] rs_y;
  logic [LW-1:0] rs_x;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [LH-1:0] BR = LH'(b / WIN_W);
    localparam logic [LW-1:0] BC = LW'(b % WIN_W);
    logic [DW-1:0] mem [DEPTH];
    logic          we;
    logic [DW-1:0] wd;

    always_comb begin
      case (wr_mode)
        2'd0:    begin we = (wy == BR) && (wx == BC); wd = wr_data[0 +: DW]; end
        2'd1:    begin we = (wy == BR); wd = wr_data[(b % WIN_W)*DW +: DW]; end
        2'd2:    begin we = (wx == BC); wd = wr_data[(b / WIN_W)*DW +: DW]; end
        default: begin we = 1'b1;       wd = wr_data[b*DW +: DW]; end
      endcase
    end

    always_ff @(posedge clk)
      if (wr_ok && we) mem[wa] <= wd;

    always_ff @(posedge clk)
      if (!rst_n)     bank_q[b] <= '0;
      else if (rd_ok) bank_q[b] <= mem[ra];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_mode  <= 2'd0;
      rs_y     <= '0;
      rs_x     <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      if (rd_ok) begin
        rs_mode <= rd_mode;
        rs_y    <= rd_row[LH-1:0];
        rs_x    <= rd_col[LW-1:0];
      end
      rd_valid <= rd_ok;
      rd_err   <= rd_en && !rd_ok;
      wr_err   <= wr_en && !wr_ok;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [DW-1:0] lane;
    always_comb begin
      lane = '0;
      case (rs_mode)
        2'd0: if (i == 0)     lane = bank_q[{rs_y, rs_x}];
        2'd1: if (i < WIN_W)  lane = bank_q[{rs_y, LW'(i % WIN_W)}];
        2'd2: if (i < WIN_H)  lane = bank_q[{LH'(i % WIN_H), rs_x}];
        default:              lane = bank_q[i];
      endcase
    end
    assign rd_data[i*DW +: DW] = lane;
  end

endmodule

// File: rtl/mat_window_store_chk.sv
module mat_window_store_chk #(
  parameter int DW    = 32,
  parameter int WIN_H = 4,
  parameter int WIN_W = 4,
  parameter int MAT_H = 32,
  parameter int MAT_W = 64,
  localparam int NB   = WIN_H * WIN_W,
  localparam int LH   = $clog2(WIN_H),
  localparam int LW   = $clog2(WIN_W),
  localparam int RW   = $clog2(MAT_H),
  localparam int CW   = $clog2(MAT_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_mode,
  input logic [RW-1:0]    wr_row,
  input logic [CW-1:0]    wr_col,
  input logic             wr_err,
  input logic             rd_en,
  input logic [1:0]       rd_mode,
  input logic [RW-1:0]    rd_row,
  input logic [CW-1:0]    rd_col,
  input logic [NB*DW-1:0] rd_data,
  input logic             rd_valid,
  input logic             rd_err
);

  wire wr_bad = (wr_mode[0] && wr_col[LW-1:0] != '0) || (wr_mode[1] && wr_row[LH-1:0] != '0);
  wire rd_bad = (rd_mode[0] && rd_col[LW-1:0] != '0) || (rd_mode[1] && rd_row[LH-1:0] != '0);

  p_read_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_bad |=> rd_valid);

  p_valid_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  p_single_lanes_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(rd_mode) == 2'd0 |-> rd_data[NB*DW-1:DW] == '0);

  p_wr_misalign_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_bad |=> wr_err);

  p_rd_misalign_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_bad |=> rd_err && !rd_valid);

  p_err_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $stable(rd_data));

endmodule

bind mat_window_store mat_window_store_chk #(
  .DW(DW), .WIN_H(WIN_H), .WIN_W(WIN_W), .MAT_H(MAT_H), .MAT_W(MAT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode), .wr_row(wr_row),
  .wr_col(wr_col), .wr_err(wr_err), .rd_en(rd_en), .rd_mode(rd_mode),
  .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data), .rd_valid(rd_valid),
  .rd_err(rd_err)
);

// File: tb/mat_window_store_tb_top.sv
module mat_window_store_tb_top;
  localparam int DW = 32, WH = 4, WW = 4, MH = 32, MW = 64;
  localparam int NB = WH * WW, RW = 5, CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_mode = 0, rd_mode = 0;
  logic [RW-1:0] wr_row = 0, rd_row = 0;
  logic [CW-1:0] wr_col = 0, rd_col = 0;
  logic [NB*DW-1:0] wr_data = '0, rd_data;
  logic wr_err, rd_valid, rd_err;

  always #2 clk = ~clk;

  mat_window_store #(.DW(DW), .WIN_H(WH), .WIN_W(WW), .MAT_H(MH), .MAT_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data), .wr_err(wr_err), .rd_en(rd_en),
    .rd_mode(rd_mode), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_err(rd_err));

  logic [DW-1:0] mdl [MH][MW];
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [NB*DW-1:0] got;

  task automatic chk(input bit ok, input string tag, input logic [NB*DW-1:0] a, e);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, a, e);
    end
  endtask

  function automatic logic [NB*DW-1:0] mk(input int seed);
    logic [NB*DW-1:0] v;
    for (int k = 0; k < NB; k++) v[k*DW +: DW] = 32'(seed * 1000 + k) ^ 32'hA500_0000;
    return v;
  endfunction

  function automatic bit aligned(input int m, y, x);
    return !(((m & 1) != 0 && x % WW != 0) || ((m & 2) != 0 && y % WH != 0));
  endfunction

  function automatic logic [NB*DW-1:0] expv(input int m, y, x);
    logic [NB*DW-1:0] v = '0;
    case (m)
      0: v[0 +: DW] = mdl[y][x];
      1: for (int c = 0; c < WW; c++) v[c*DW +: DW] = mdl[y][x+c];
      2: for (int r = 0; r < WH; r++) v[r*DW +: DW] = mdl[y+r][x];
      default: for (int r = 0; r < WH; r++) for (int c = 0; c < WW; c++)
                 v[(r*WW+c)*DW +: DW] = mdl[y+r][x+c];
    endcase
    return v;
  endfunction

  task automatic mdl_write(input int m, y, x, input logic [NB*DW-1:0] d);
    case (m)
      0: mdl[y][x] = d[0 +: DW];
      1: for (int c = 0; c < WW; c++) mdl[y][x+c] = d[c*DW +: DW];
      2: for (int r = 0; r < WH; r++) mdl[y+r][x] = d[r*DW +: DW];
      default: for (int r = 0; r < WH; r++) for (int c = 0; c < WW; c++)
                 mdl[y+r][x+c] = d[(r*WW+c)*DW +: DW];
    endcase
  endtask

  task automatic do_write(input int m, y, x, input logic [NB*DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_mode = 2'(m); wr_row = RW'(y); wr_col = CW'(x); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (aligned(m, y, x)) mdl_write(m, y, x, d);
  endtask

  task automatic do_read(input int m, y, x);
    @(negedge clk);
    rd_en = 1; rd_mode = 2'(m); rd_row = RW'(y); rd_col = CW'(x);
    @(negedge clk);
    rd_en = 0;
    got = rd_data;
  endtask

  task automatic read_check(input int m, y, x, input string tag);
    logic [NB*DW-1:0] e;
    do_read(m, y, x);
    e = expv(m, y, x);
    chk(got === e && rd_valid === 1'b1, tag, got, e);
  endtask

  task automatic t_reset;
    chk(rd_valid === 0 && rd_err === 0 && wr_err === 0, "reset flags", 0, 0);
    chk(rd_data === '0, "reset rd_data", rd_data, '0);
  endtask

  task automatic t_fill_tiles;
    for (int ty = 0; ty < MH / WH; ty++)
      for (int tx = 0; tx < MW / WW; tx++) do_write(3, ty*WH, tx*WW, mk(ty*16 + tx));
    for (int ty = 0; ty < MH / WH; ty++)
      for (int tx = 0; tx < MW / WW; tx++) read_check(3, ty*WH, tx*WW, "R5 tile readback");
  endtask

  task automatic t_single;
    logic [NB*DW-1:0] e;
    do_write(0, 9, 14, mk(501));
    do_write(0, 31, 63, mk(502));
    do_write(0, 0, 0, mk(503));
    read_check(0, 9, 14, "R2 single read");
    read_check(0, 31, 63, "R2 single corner");
    read_check(3, 8, 12, "R2 single leaves tile");
    do_read(3, 8, 12);
    e = '0; e[DW-1:0] = mdl[9][14];
    chk(got[((9%WH)*WW + 14%WW)*DW +: DW] === mdl[9][14], "R1 bank lane", got, e);
    do_read(3, 28, 60);
    chk(got[(NB-1)*DW +: DW] === mdl[31][63], "R1 last lane", got, e);
  endtask

  task automatic t_row;
    do_write(1, 5, 8, mk(601));
    read_check(1, 5, 8, "R3 row slice");
    read_check(3, 4, 8, "R8 row write masked");
    do_write(1, 2, 60, mk(602));
    read_check(1, 2, 60, "R3 row last tile");
  endtask

  task automatic t_col;
    do_write(2, 4, 3, mk(701));
    read_check(2, 4, 3, "R4 col slice");
    read_check(3, 4, 0, "R8 col write masked");
    read_check(2, 28, 33, "R4 col other");
  endtask

  task automatic t_zero_lanes;
    do_read(0, 7, 7);
    chk(got[NB*DW-1:DW] === '0, "R7 single zero", got, '0);
    do_read(1, 5, 8);
    chk(got[NB*DW-1:WW*DW] === '0, "R7 row zero", got, '0);
    do_read(2, 4, 3);
    chk(got[NB*DW-1:WH*DW] === '0, "R7 col zero", got, '0);
  endtask

  task automatic t_latency;
    do_read(3, 0, 0);
    chk(rd_valid === 1'b1, "R6 valid after request", {31'd0, rd_valid}, 1);
    @(negedge clk);
    chk(rd_valid === 1'b0, "R6 valid drops", {31'd0, rd_valid}, 0);
  endtask

  task automatic t_misalign;
    logic [NB*DW-1:0] prev;
    do_write(1, 12, 17, mk(801));
    chk(wr_err === 1'b1, "R9 wr_err row", {31'd0, wr_err}, 1);
    read_check(3, 12, 16, "R9 misaligned write ignored");
    do_write(2, 13, 20, mk(802));
    chk(wr_err === 1'b1, "R9 wr_err col", {31'd0, wr_err}, 1);
    read_check(3, 12, 20, "R9 col misaligned ignored");
    do_write(3, 12, 16, mk(803));
    chk(wr_err === 1'b0, "R9 no err aligned", {31'd0, wr_err}, 0);
    read_check(3, 12, 16, "R9 aligned tile write");
    prev = got;
    do_read(3, 1, 4);
    chk(rd_err === 1'b1 && rd_valid === 1'b0, "R9 rd flags", {rd_err, rd_valid}, 2'b10);
    chk(got === prev, "R9 rd_data held", got, prev);
  endtask

  task automatic t_collide;
    logic [NB*DW-1:0] old, nw;
    old = expv(3, 16, 32);
    nw  = mk(901);
    @(negedge clk);
    rd_en = 1; rd_mode = 2'd3; rd_row = RW'(16); rd_col = CW'(32);
    wr_en = 1; wr_mode = 2'd3; wr_row = RW'(16); wr_col = CW'(32); wr_data = nw;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    chk(rd_data === old, "R10 old data on collision", rd_data, old);
    mdl_write(3, 16, 32, nw);
    read_check(3, 16, 32, "R10 new data after");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1;
    t_fill_tiles;
    t_single;
    t_row;
    t_col;
    t_zero_lanes;
    t_latency;
    t_misalign;
    t_collide;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired got 1 exp 0");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule